// File: doc/BRIEF.md
# Soft Reset and Stop Sequencer for a Display Controller

This block sits between the bus-side control register of a display controller and its frame datapath. Software changes three control bits (run, clock gate and soft reset) through a set strobe and a clear strobe. Both strobes share one bit mask, so a single bit can change without a read-modify-write. Raising soft reset holds the downstream datapath in reset. The block then waits a fixed drain time and sets the clock-gate bit itself. Software polls that bit to learn that the reset has finished, then clears the clock gate and the soft reset to release the block.

The run bit carries a deferred stop. Clearing it only records a stop request, and the bit keeps reading 1 until the next end-of-frame pulse. While running, each end-of-frame pulse makes the small datapath model latch the next buffer address, count the frame and pulse a strobe. Soft reset forces every one of those registers back to zero.

Top module: `srst_seq_top`

## Requirements
- R1: After the asynchronous reset, the control readback (bit 0 run, bit 1 clock gate, bit 2 soft reset) reads 000, and the buffer address, frame count and frame strobe read zero.
- R2: A set strobe sets, and a clear strobe clears, each control bit whose mask bit is 1. The change is seen after the next clock edge and leaves unmasked bits alone. If both strobes name the same bit in one cycle, the set wins.
- R3: Once soft reset reads 1, the clock-gate bit is set by the block exactly DRAIN_CYCLES clock edges later and reads 0 before that.
- R4: After the block has set the clock gate, clearing the clock gate while soft reset stays 1 does not start a second drain. The clock gate stays 0.
- R5: Clearing soft reset takes effect at the next edge whether or not the drain has finished. An unfinished drain is abandoned and never sets the clock gate.
- R6: From the edge that sets soft reset until the edge that clears it, the run bit reads 0 and set requests for it are ignored. In the same span the buffer address, frame count and frame strobe read 0 and end-of-frame pulses are ignored.
- R7: Clearing the run bit while it reads 1 does not stop it at once. It keeps reading 1 until the first end-of-frame pulse after the request, and reads 0 from the edge that samples that pulse.
- R8: An end-of-frame pulse in the same cycle as the clear request does not complete the stop.
- R9: Setting the run bit while a stop is pending cancels the stop, so later end-of-frame pulses leave the run bit at 1.
- R10: An end-of-frame pulse sampled while the run bit reads 1 loads the buffer address from the next-address input and increments the frame count. It also drives the frame strobe high for exactly the following cycle. With the run bit at 0 the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setStb | input | 1 | Set strobe for the masked control bits |
| clrStb | input | 1 | Clear strobe for the masked control bits |
| bitMask | input | 3 | Control bits addressed by the strobes |
| frameEnd | input | 1 | One-cycle end-of-frame pulse |
| nextBufAddr | input | ADDR_W | Buffer address taken at each accepted frame end |
| ctrlRd | output | 3 | Control readback {soft reset, clock gate, run} |
| curBufAddr | output | ADDR_W | Current buffer address |
| frameCount | output | CNT_W | Accepted frame count |
| frameStrobe | output | 1 | One-cycle pulse after an accepted frame end |

## Verification
Every strobe and frame pulse is sampled on a rising edge, and its result shows up on the outputs one edge later. The only exception is the hardware clock-gate set, which comes DRAIN_CYCLES edges after soft reset reads 1. The driver applies inputs on the falling edge and queues an item due one cycle later. The monitor compares each item on the falling edge of the cycle it is due. The drain is checked on every step of the window, so an early or late gate is caught. The stop cases check the run bit on the steps before, during and after the completing end-of-frame pulse.

// File: rtl/srst_seq_pkg.sv
package srst_seq_pkg;
  localparam int RunIdx  = 0;
  localparam int GateIdx = 1;
  localparam int SrstIdx = 2;
  localparam int CtrlW   = 3;

  typedef struct packed {
    logic hold;    // force datapath registers to reset values
    logic accept;  // take the current end-of-frame pulse
  } dpCtl_t;
endpackage

// File: rtl/srst_seq_ctrl.sv
module srst_seq_ctrl
  import srst_seq_pkg::*;
#(
  parameter int DRAIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setStb,
  input  logic             clrStb,
  input  logic [CtrlW-1:0] bitMask,
  input  logic             frameEnd,
  output logic [CtrlW-1:0] ctrlRd,
  output dpCtl_t           dpCtl
);
  localparam int DrainW = $clog2(DRAIN_CYCLES + 1);
  localparam logic [DrainW-1:0] DrainLast = DrainW'(DRAIN_CYCLES - 1);

  logic softRst, clkGate, runBit, stopPending, drained;
  logic [DrainW-1:0] drainCnt;
  logic [CtrlW-1:0] setM, clrM, applied;
  logic softRstNext, drainHit;

  assign setM = setStb ? bitMask : '0;
  assign clrM = clrStb ? bitMask : '0;
  assign applied = ({softRst, clkGate, runBit} & ~clrM) | setM;
  assign softRstNext = applied[SrstIdx];
  assign drainHit = softRst && !drained && (drainCnt == DrainLast);

  // soft reset and drain handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRst  <= 1'b0;
      clkGate  <= 1'b0;
      drained  <= 1'b0;
      drainCnt <= '0;
    end else begin
      softRst <= softRstNext;
      clkGate <= drainHit ? 1'b1 : applied[GateIdx];
      if (!softRstNext) drained <= 1'b0;
      else if (drainHit) drained <= 1'b1;
      if (!softRst || !softRstNext || drained || drainHit) drainCnt <= '0;
      else drainCnt <= drainCnt + 1'b1;
    end
  end

  // run bit with deferred stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit      <= 1'b0;
      stopPending <= 1'b0;
    end else if (softRstNext) begin
      runBit      <= 1'b0;
      stopPending <= 1'b0;
    end else if (setM[RunIdx]) begin
      runBit      <= 1'b1;
      stopPending <= 1'b0;
    end else if (frameEnd && stopPending) begin
      runBit      <= 1'b0;
      stopPending <= 1'b0;
    end else if (clrM[RunIdx] && runBit) begin
      stopPending <= 1'b1;
    end
  end

  assign ctrlRd = {softRst, clkGate, runBit};
  assign dpCtl.hold   = softRstNext;
  assign dpCtl.accept = frameEnd && runBit && !softRstNext;

  assert_drain_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    drainCnt <= DrainLast);
  assert_gate_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkGate) |-> ($past(setStb && bitMask[GateIdx]) || $past(softRst && !drained)));
  assert_run_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runBit) |-> ($past(softRstNext) || ($past(frameEnd) && $past(stopPending))));
  assert_reset_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> !runBit);
endmodule

// File: rtl/srst_seq_dpath.sv
module srst_seq_dpath
  import srst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] nextBufAddr,
  output logic [ADDR_W-1:0] curBufAddr,
  output logic [CNT_W-1:0]  frameCount,
  output logic              frameStrobe
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBufAddr  <= '0;
      frameCount  <= '0;
      frameStrobe <= 1'b0;
    end else if (dpCtl.hold) begin
      curBufAddr  <= '0;
      frameCount  <= '0;
      frameStrobe <= 1'b0;
    end else begin
      frameStrobe <= dpCtl.accept;
      if (dpCtl.accept) begin
        curBufAddr <= nextBufAddr;
        frameCount <= frameCount + 1'b1;
      end
    end
  end

  assert_hold_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.hold |=> (curBufAddr == '0 && frameCount == '0 && !frameStrobe));
  assert_strobe_src_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |-> $past(dpCtl.accept));
endmodule

// File: rtl/srst_seq_top.sv
module srst_seq_top
  import srst_seq_pkg::*;
#(
  parameter int DRAIN_CYCLES = 4,
  parameter int ADDR_W       = 16,
  parameter int CNT_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setStb,
  input  logic              clrStb,
  input  logic [2:0]        bitMask,
  input  logic              frameEnd,
  input  logic [ADDR_W-1:0] nextBufAddr,
  output logic [2:0]        ctrlRd,
  output logic [ADDR_W-1:0] curBufAddr,
  output logic [CNT_W-1:0]  frameCount,
  output logic              frameStrobe
);
  dpCtl_t dpCtl;

  srst_seq_ctrl #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .setStb(setStb), .clrStb(clrStb),
    .bitMask(bitMask), .frameEnd(frameEnd), .ctrlRd(ctrlRd), .dpCtl(dpCtl)
  );

  srst_seq_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .nextBufAddr(nextBufAddr),
    .curBufAddr(curBufAddr), .frameCount(frameCount), .frameStrobe(frameStrobe)
  );
endmodule

// File: tb/srst_seq_top_bench.sv
module srst_seq_top_bench;
  localparam int ClkPeriod = 10;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setStb = 1'b0, clrStb = 1'b0, frameEnd = 1'b0;
  logic [2:0] bitMask = '0;
  logic [AW-1:0] nextBufAddr = '0;
  logic [2:0] ctrlRd;
  logic [AW-1:0] curBufAddr;
  logic [CW-1:0] frameCount;
  logic frameStrobe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int due;
    logic [2:0] ctrl;
    bit chkDp;
    logic [AW-1:0] addr;
    logic [CW-1:0] cnt;
    logic stb;
    string tag;
  } item_t;
  item_t expQ[$];

  srst_seq_top #(.DRAIN_CYCLES(4), .ADDR_W(AW), .CNT_W(CW)) u_srst_seq_top (
    .clk(clk), .rstN(rstN), .setStb(setStb), .clrStb(clrStb), .bitMask(bitMask),
    .frameEnd(frameEnd), .nextBufAddr(nextBufAddr), .ctrlRd(ctrlRd),
    .curBufAddr(curBufAddr), .frameCount(frameCount), .frameStrobe(frameStrobe)
  );

  always #(ClkPeriod / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // driver: apply one cycle of stimulus and queue the result due after the next edge
  task automatic step(input logic s, input logic c, input logic [2:0] m, input logic fe,
                      input logic [AW-1:0] a, input logic [2:0] eCtrl, input bit dp,
                      input logic [AW-1:0] eAddr, input logic [CW-1:0] eCnt,
                      input logic eStb, input string tag);
    item_t it;
    @(negedge clk);
    setStb = s; clrStb = c; bitMask = m; frameEnd = fe; nextBufAddr = a;
    it.due = cyc + 1; it.ctrl = eCtrl; it.chkDp = dp; it.addr = eAddr;
    it.cnt = eCnt; it.stb = eStb; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input logic [2:0] eCtrl, input string tag);
    step(0, 0, 3'b000, 0, '0, eCtrl, 0, '0, '0, 0, tag);
  endtask

  // monitor: compare each queued item on the falling edge of its due cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due == cyc) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (ctrlRd !== it.ctrl ||
          (it.chkDp && (curBufAddr !== it.addr || frameCount !== it.cnt || frameStrobe !== it.stb))) begin
        errors++;
        $display("FAIL %s: ctrl=%b addr=%h cnt=%0d stb=%b expected ctrl=%b addr=%h cnt=%0d stb=%b",
                 it.tag, ctrlRd, curBufAddr, frameCount, frameStrobe,
                 it.ctrl, it.addr, it.cnt, it.stb);
      end
    end
  end

  initial begin
    #(ClkPeriod * 5000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 3'b000, 0, '0, 3'b000, 1, '0, '0, 0, "R1 reset state");
    step(1, 0, 3'b001, 0, '0, 3'b001, 1, '0, '0, 0, "R2 set run");
    step(0, 0, 3'b000, 1, 16'h005A, 3'b001, 1, 16'h005A, 8'd1, 1, "R10 frame accepted");
    step(0, 0, 3'b000, 0, '0, 3'b001, 1, 16'h005A, 8'd1, 0, "R10 strobe one cycle");
    step(0, 0, 3'b000, 1, 16'h0033, 3'b001, 1, 16'h0033, 8'd2, 1, "R10 second frame");
    step(0, 1, 3'b001, 0, '0, 3'b001, 0, '0, '0, 0, "R7 clear deferred");
    idle(3'b001, "R7 still running");
    step(0, 0, 3'b000, 1, 16'h0044, 3'b000, 1, 16'h0044, 8'd3, 1, "R7 stop at frame end");
    step(0, 0, 3'b000, 1, 16'h0077, 3'b000, 1, 16'h0044, 8'd3, 0, "R10 ignored when stopped");
    step(1, 0, 3'b001, 0, '0, 3'b001, 0, '0, '0, 0, "R2 set run again");
    step(0, 1, 3'b001, 1, 16'h0010, 3'b001, 1, 16'h0010, 8'd4, 1, "R8 same-cycle frame end");
    step(0, 0, 3'b000, 1, 16'h0011, 3'b000, 1, 16'h0011, 8'd5, 1, "R8 next frame end stops");
    step(1, 0, 3'b001, 0, '0, 3'b001, 0, '0, '0, 0, "R9 set run");
    step(0, 1, 3'b001, 0, '0, 3'b001, 0, '0, '0, 0, "R9 stop request");
    step(1, 0, 3'b001, 0, '0, 3'b001, 0, '0, '0, 0, "R9 cancel");
    step(0, 0, 3'b000, 1, 16'h0022, 3'b001, 1, 16'h0022, 8'd6, 1, "R9 run kept");
    step(1, 1, 3'b010, 0, '0, 3'b011, 0, '0, '0, 0, "R2 set wins over clear");
    step(0, 1, 3'b010, 0, '0, 3'b001, 0, '0, '0, 0, "R2 clear gate");
    step(1, 0, 3'b100, 0, '0, 3'b100, 1, '0, '0, 0, "R6 soft reset clears run and datapath");
    step(1, 0, 3'b001, 1, 16'h0099, 3'b100, 1, '0, '0, 0, "R6 run set and frame ignored");
    idle(3'b100, "R3 drain wait 2");
    idle(3'b100, "R3 drain wait 3");
    idle(3'b110, "R3 gate set by block");
    step(0, 1, 3'b010, 0, '0, 3'b100, 0, '0, '0, 0, "R4 clear gate");
    for (int i = 0; i < 6; i++) idle(3'b100, "R4 no second drain");
    step(0, 1, 3'b100, 0, '0, 3'b000, 1, '0, '0, 0, "R5 release");
    step(1, 0, 3'b001, 0, '0, 3'b001, 0, '0, '0, 0, "R2 run after release");
    step(0, 0, 3'b000, 1, 16'h0066, 3'b001, 1, 16'h0066, 8'd1, 1, "R10 count restarts");
    step(1, 0, 3'b100, 0, '0, 3'b100, 1, '0, '0, 0, "R6 soft reset again");
    step(0, 1, 3'b100, 0, '0, 3'b000, 0, '0, '0, 0, "R5 early release");
    for (int i = 0; i < 6; i++) idle(3'b000, "R5 abandoned drain");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule